// File: doc/BRIEF.md
# Store Issue Gate with Wraparound Stall

This block decides, cycle by cycle, whether the store entry at the head of a store queue may be written to memory. It looks up the entry that the issue pointer selects, checks that entry against every load in the load queue for ordering and address hazards, and raises a write request only when the entry is complete and no older, unfinished load could be affected. When the memory side accepts the write, the issue pointer moves to the next entry, wrapping at the queue depth.

Entries stay allocated while their writes are in flight, so a small queue facing a long memory latency can wrap the issue pointer onto an entry that has already been written. A one-bit stall state guards against this. It is set when an accepted write leaves the issue pointer equal to the tail pointer. It is released only when the allocator moves the tail, which it does when a new group brings at least one store.

The allocator supplies the new tail value with an update strobe, and the block keeps the tail register. Write address and data are forced to zero whenever no request is raised.

Top module: `store_issue_gate`

## Requirements
- R1: A load blocks the candidate store when it is allocated, not completed, older than the store and has an equal, valid address. The load is older when bit `i*SQ_DEPTH + j` of `st_older` is 0, for load i and store entry j. The check covers every load index, including the last one.
- R2: An allocated, uncompleted, older load whose address is not yet valid blocks the candidate store, whatever its address bits hold.
- R3: A load that is unallocated, completed, or younger than the store (order bit 1) never blocks it, even when the addresses are equal.
- R4: `wr_valid` is raised only when the entry at `issue_ptr` is allocated and has a valid address and valid data.
- R5: When `wr_valid` is 1, `wr_addr` and `wr_data` carry the selected entry's address and data. When `wr_valid` is 0, both outputs are zero.
- R6: `issue_ptr` increments by one, from `SQ_DEPTH-1` back to 0, exactly on cycles where `wr_valid` and `wr_ready` are both 1. Otherwise it holds its value.
- R7: An accepted write that leaves the issue pointer equal to the registered tail pointer sets the stall state. While the stall state is set, `wr_valid` stays 0 even if the entry at `issue_ptr` is valid.
- R8: A cycle with `tail_upd` high clears the stall state for the next cycle. It also loads `tail_next` into the tail register. If the stall state would be set in that same cycle, the clear wins.
- R9: Synchronous reset sets `issue_ptr`, the tail register and the stall state to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_alloc | input | LQ_DEPTH | Load entry allocated |
| ld_done | input | LQ_DEPTH | Load already received its data |
| ld_addr_ok | input | LQ_DEPTH | Load address known |
| ld_addr | input | LQ_DEPTH*ADDR_W | Load addresses, entry i at bits i*ADDR_W |
| st_older | input | LQ_DEPTH*SQ_DEPTH | Bit i*SQ_DEPTH+j set: store j is older than load i |
| st_alloc | input | SQ_DEPTH | Store entry allocated |
| st_addr_ok | input | SQ_DEPTH | Store address known |
| st_data_ok | input | SQ_DEPTH | Store data known |
| st_addr | input | SQ_DEPTH*ADDR_W | Store addresses |
| st_data | input | SQ_DEPTH*DATA_W | Store data |
| tail_upd | input | 1 | Allocator moves the store tail this cycle |
| tail_next | input | PTR_W | New store tail value |
| wr_ready | input | 1 | Memory write channel accepts |
| wr_valid | output | 1 | Write request |
| wr_addr | output | ADDR_W | Write address, zero when idle |
| wr_data | output | DATA_W | Write data, zero when idle |
| issue_ptr | output | PTR_W | Current store issue pointer |

## Verification
Several properties are checked on every cycle. The stall state always suppresses the request, and a tail update always leaves the stall cleared. The issue pointer moves exactly on handshakes, idle outputs are zero, and any request points at a complete entry. Other behaviour appears only in the bench's scenarios. These cover the hazard decision for each load condition (equal address, unknown address, completed, younger, unallocated, last load index). They also cover the exact write order through a full wrap of the queue, the stall that follows a wrap onto a still-valid entry, and the clear-over-set priority.

// File: rtl/sig_pkg.sv
package sig_pkg;
  typedef enum logic {
    ISSUE_FREE = 1'b0,
    ISSUE_HELD = 1'b1
  } stall_e;
endpackage

// File: rtl/sig_load_scan.sv
module sig_load_scan #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 10,
  parameter int PTR_W    = 3
) (
  input  logic [LQ_DEPTH-1:0]          ld_alloc,
  input  logic [LQ_DEPTH-1:0]          ld_done,
  input  logic [LQ_DEPTH-1:0]          ld_addr_ok,
  input  logic [LQ_DEPTH*ADDR_W-1:0]   ld_addr,
  input  logic [LQ_DEPTH*SQ_DEPTH-1:0] st_older,
  input  logic [PTR_W-1:0]             issue_ptr,
  input  logic [ADDR_W-1:0]            cand_addr,
  output logic                         any_conflict
);
  logic [LQ_DEPTH-1:0] hit;

  for (genvar i = 0; i < LQ_DEPTH; i++) begin : g_load
    logic [SQ_DEPTH-1:0] row;
    logic                load_first;
    logic                hazard;
    assign row        = st_older[i*SQ_DEPTH +: SQ_DEPTH];
    assign load_first = ~row[issue_ptr];
    assign hazard     = ~ld_addr_ok[i] | (ld_addr[i*ADDR_W +: ADDR_W] == cand_addr);
    assign hit[i]     = ld_alloc[i] & ~ld_done[i] & load_first & hazard;
  end

  assign any_conflict = |hit;
endmodule

// File: rtl/sig_entry_pick.sv
module sig_entry_pick #(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int PTR_W    = 3
) (
  input  logic [SQ_DEPTH-1:0]        st_alloc,
  input  logic [SQ_DEPTH-1:0]        st_addr_ok,
  input  logic [SQ_DEPTH-1:0]        st_data_ok,
  input  logic [SQ_DEPTH*ADDR_W-1:0] st_addr,
  input  logic [SQ_DEPTH*DATA_W-1:0] st_data,
  input  logic [PTR_W-1:0]           sel,
  output logic                       ready_entry,
  output logic [ADDR_W-1:0]          sel_addr,
  output logic [DATA_W-1:0]          sel_data
);
  always_comb begin
    ready_entry = 1'b0;
    sel_addr    = '0;
    sel_data    = '0;
    for (int j = 0; j < SQ_DEPTH; j++) begin
      if (sel == PTR_W'(j)) begin
        ready_entry = st_alloc[j] & st_addr_ok[j] & st_data_ok[j];
        sel_addr    = st_addr[j*ADDR_W +: ADDR_W];
        sel_data    = st_data[j*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/sig_wrap_stall.sv
module sig_wrap_stall
  import sig_pkg::*;
#(
  parameter int SQ_DEPTH = 8,
  parameter int PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue_go,
  input  logic             tail_upd,
  input  logic [PTR_W-1:0] tail_next,
  output logic [PTR_W-1:0] issue_ptr,
  output logic             stalled
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(SQ_DEPTH - 1);

  logic [PTR_W-1:0] ptr_q, tail_q, ptr_inc;
  stall_e           state_q;
  logic             catch_up;

  assign ptr_inc  = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  assign catch_up = issue_go & (ptr_inc == tail_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      tail_q  <= '0;
      state_q <= ISSUE_FREE;
    end else begin
      if (issue_go) ptr_q <= ptr_inc;
      if (tail_upd) tail_q <= tail_next;
      if (tail_upd)      state_q <= ISSUE_FREE;
      else if (catch_up) state_q <= ISSUE_HELD;
    end
  end

  assign issue_ptr = ptr_q;
  assign stalled   = (state_q == ISSUE_HELD);
endmodule

// File: rtl/store_issue_gate.sv
module store_issue_gate #(
  parameter int LQ_DEPTH = 8,
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  localparam int PTR_W   = (SQ_DEPTH > 1) ? $clog2(SQ_DEPTH) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LQ_DEPTH-1:0]          ld_alloc,
  input  logic [LQ_DEPTH-1:0]          ld_done,
  input  logic [LQ_DEPTH-1:0]          ld_addr_ok,
  input  logic [LQ_DEPTH*ADDR_W-1:0]   ld_addr,
  input  logic [LQ_DEPTH*SQ_DEPTH-1:0] st_older,
  input  logic [SQ_DEPTH-1:0]          st_alloc,
  input  logic [SQ_DEPTH-1:0]          st_addr_ok,
  input  logic [SQ_DEPTH-1:0]          st_data_ok,
  input  logic [SQ_DEPTH*ADDR_W-1:0]   st_addr,
  input  logic [SQ_DEPTH*DATA_W-1:0]   st_data,
  input  logic                         tail_upd,
  input  logic [PTR_W-1:0]             tail_next,
  input  logic                         wr_ready,
  output logic                         wr_valid,
  output logic [ADDR_W-1:0]            wr_addr,
  output logic [DATA_W-1:0]            wr_data,
  output logic [PTR_W-1:0]             issue_ptr
);
  logic              entry_ok;
  logic [ADDR_W-1:0] cand_addr;
  logic [DATA_W-1:0] cand_data;
  logic              conflict;
  logic              stall_w;
  logic              fire;

  sig_entry_pick #(
    .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
  ) u_pick (
    .st_alloc(st_alloc), .st_addr_ok(st_addr_ok), .st_data_ok(st_data_ok),
    .st_addr(st_addr), .st_data(st_data), .sel(issue_ptr),
    .ready_entry(entry_ok), .sel_addr(cand_addr), .sel_data(cand_data)
  );

  sig_load_scan #(
    .LQ_DEPTH(LQ_DEPTH), .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .PTR_W(PTR_W)
  ) u_scan (
    .ld_alloc(ld_alloc), .ld_done(ld_done), .ld_addr_ok(ld_addr_ok),
    .ld_addr(ld_addr), .st_older(st_older), .issue_ptr(issue_ptr),
    .cand_addr(cand_addr), .any_conflict(conflict)
  );

  sig_wrap_stall #(
    .SQ_DEPTH(SQ_DEPTH), .PTR_W(PTR_W)
  ) u_stall (
    .clk(clk), .rst(rst), .issue_go(fire), .tail_upd(tail_upd),
    .tail_next(tail_next), .issue_ptr(issue_ptr), .stalled(stall_w)
  );

  assign wr_valid = entry_ok & ~conflict & ~stall_w;
  assign fire     = wr_valid & wr_ready;
  assign wr_addr  = wr_valid ? cand_addr : '0;
  assign wr_data  = wr_valid ? cand_data : '0;
endmodule

// File: rtl/sig_gate_chk.sv
module sig_gate_chk #(
  parameter int SQ_DEPTH = 8,
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 32,
  parameter int PTR_W    = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_valid,
  input logic                wr_ready,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic [PTR_W-1:0]    issue_ptr,
  input logic                tail_upd,
  input logic                stall,
  input logic [SQ_DEPTH-1:0] st_alloc,
  input logic [SQ_DEPTH-1:0] st_addr_ok,
  input logic [SQ_DEPTH-1:0] st_data_ok
);
  // R4
  entry_complete_chk: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (st_alloc[issue_ptr] && st_addr_ok[issue_ptr] && st_data_ok[issue_ptr]));

  // R5
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |-> (wr_addr == '0 && wr_data == '0));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_valid && wr_ready) |=> $stable(issue_ptr));

  // R6
  ptr_move_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> (issue_ptr != $past(issue_ptr)));

  // R7
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    stall |-> !wr_valid);

  // R8
  clear_wins_chk: assert property (@(posedge clk) disable iff (rst)
    tail_upd |=> !stall);
endmodule

bind store_issue_gate sig_gate_chk #(
  .SQ_DEPTH(SQ_DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PTR_W(PTR_W)
) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .wr_addr(wr_addr), .wr_data(wr_data), .issue_ptr(issue_ptr),
  .tail_upd(tail_upd), .stall(stall_w), .st_alloc(st_alloc),
  .st_addr_ok(st_addr_ok), .st_data_ok(st_data_ok)
);

// File: tb/sim_store_issue_gate.sv
module sim_store_issue_gate;
  localparam int LQ = 8, SQ = 8, AW = 10, DW = 32, PW = 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst = 1'b1;
  logic [LQ-1:0] ld_alloc = '0, ld_done = '0, ld_addr_ok = '0;
  logic [LQ*AW-1:0] ld_addr = '0;
  logic [LQ*SQ-1:0] st_older = '0;
  logic [SQ-1:0] st_alloc = '0, st_addr_ok = '0, st_data_ok = '0;
  logic [SQ*AW-1:0] st_addr = '0;
  logic [SQ*DW-1:0] st_data = '0;
  logic tail_upd = 1'b0, wr_ready = 1'b0;
  logic [PW-1:0] tail_next = '0;
  logic wr_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data;
  logic [PW-1:0] issue_ptr;

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  logic [AW+DW-1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  store_issue_gate #(.LQ_DEPTH(LQ), .SQ_DEPTH(SQ), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .ld_alloc(ld_alloc), .ld_done(ld_done),
    .ld_addr_ok(ld_addr_ok), .ld_addr(ld_addr), .st_older(st_older),
    .st_alloc(st_alloc), .st_addr_ok(st_addr_ok), .st_data_ok(st_data_ok),
    .st_addr(st_addr), .st_data(st_data), .tail_upd(tail_upd),
    .tail_next(tail_next), .wr_ready(wr_ready), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .issue_ptr(issue_ptr)
  );

  function automatic logic [AW-1:0] s_addr(int j); return AW'(10'h100 + j*4); endfunction
  function automatic logic [DW-1:0] s_data(int j); return 32'hD000_0000 + j; endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_store(int j);
    st_alloc[j] = 1'b1; st_addr_ok[j] = 1'b1; st_data_ok[j] = 1'b1;
    st_addr[j*AW +: AW] = s_addr(j);
    st_data[j*DW +: DW] = s_data(j);
  endtask

  task automatic set_load(int i, bit al, bit dn, bit aok, logic [AW-1:0] a, bit younger);
    ld_alloc[i] = al; ld_done[i] = dn; ld_addr_ok[i] = aok;
    ld_addr[i*AW +: AW] = a;
    st_older[i*SQ + 0] = younger;
  endtask

  task automatic push_exp(int j); expq.push_back({s_addr(j), s_data(j)}); endtask

  // apply inputs, wait for the sampling point (negedge)
  task automatic settle; @(negedge clk); endtask
  task automatic tick; @(posedge clk); #1; endtask

  task automatic step(bit rdy, bit upd, logic [PW-1:0] tn);
    wr_ready = rdy; tail_upd = upd; tail_next = tn;
    tick();
    wr_ready = 1'b0; tail_upd = 1'b0;
  endtask

  // scoreboard monitor: compares every accepted write
  always @(negedge clk) begin
    if (!rst && wr_valid && wr_ready) begin
      checks++;
      if (expq.size() == 0) begin
        fails++;
        $display("FAIL R6 unexpected write actual=%0h expected=none", {wr_addr, wr_data});
      end else begin
        logic [AW+DW-1:0] e;
        e = expq.pop_front();
        if ({wr_addr, wr_data} !== e) begin
          fails++;
          $display("FAIL R5 write payload actual=%0h expected=%0h", {wr_addr, wr_data}, e);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    settle();
    chk("R9 ptr after reset", 64'(issue_ptr), 0);
    chk("R9 idle after reset", 64'(wr_valid), 0);
    tick();

    // stores 0..3 allocated, tail moves to 4
    for (int j = 0; j < 4; j++) set_store(j);
    step(1'b0, 1'b1, 3'd4);

    set_load(0, 1, 0, 1, s_addr(0), 0);
    settle();
    chk("R1 equal addr blocks", 64'(wr_valid), 0);
    chk("R5 idle addr zero", 64'(wr_addr), 0);
    chk("R5 idle data zero", 64'(wr_data), 0);
    tick();
    set_load(0, 1, 0, 1, 10'h3F0, 0);
    settle();
    chk("R1 different addr passes", 64'(wr_valid), 1);
    chk("R5 addr gated out", 64'(wr_addr), 64'(s_addr(0)));
    chk("R5 data gated out", 64'(wr_data), 64'(s_data(0)));
    tick();
    set_load(0, 1, 0, 0, 10'h3F0, 0);
    settle(); chk("R2 unknown load addr blocks", 64'(wr_valid), 0); tick();
    set_load(0, 1, 1, 1, s_addr(0), 0);
    settle(); chk("R3 completed load ignored", 64'(wr_valid), 1); tick();
    set_load(0, 1, 0, 1, s_addr(0), 1);
    settle(); chk("R3 younger load ignored", 64'(wr_valid), 1); tick();
    set_load(0, 0, 0, 1, s_addr(0), 0);
    settle(); chk("R3 unallocated load ignored", 64'(wr_valid), 1); tick();
    set_load(LQ-1, 1, 0, 1, s_addr(0), 0);
    settle(); chk("R1 last load index blocks", 64'(wr_valid), 0); tick();
    set_load(LQ-1, 0, 0, 0, '0, 0);

    st_data_ok[0] = 1'b0;
    settle(); chk("R4 data not valid", 64'(wr_valid), 0); tick();
    st_data_ok[0] = 1'b1; st_addr_ok[0] = 1'b0;
    settle(); chk("R4 addr not valid", 64'(wr_valid), 0); tick();
    st_addr_ok[0] = 1'b1; st_alloc[0] = 1'b0;
    settle(); chk("R4 not allocated", 64'(wr_valid), 0); tick();
    set_store(0);
    step(1'b0, 1'b0, '0);
    settle(); chk("R6 holds without ready", 64'(issue_ptr), 0); tick();

    for (int j = 4; j < SQ; j++) set_store(j);
    for (int j = 0; j < 4; j++) begin
      push_exp(j);
      step(1'b1, 1'b0, '0);
      settle(); chk("R6 ptr advance", 64'(issue_ptr), 64'((j + 1) % SQ)); tick();
    end
    settle(); chk("R7 stall at tail, entry valid", 64'(wr_valid), 0); tick();
    step(1'b1, 1'b0, '0);
    settle(); chk("R7 ptr frozen in stall", 64'(issue_ptr), 4); tick();

    step(1'b1, 1'b1, 3'd0);
    settle(); chk("R8 tail update releases", 64'(wr_valid), 1); tick();
    for (int j = 4; j < SQ; j++) begin
      push_exp(j);
      step(1'b1, 1'b0, '0);
    end
    settle();
    chk("R6 ptr wraps to 0", 64'(issue_ptr), 0);
    chk("R7 wrapped onto in-flight entry", 64'(wr_valid), 0);
    tick();

    step(1'b1, 1'b1, 3'd2);
    push_exp(0);
    step(1'b1, 1'b0, '0);
    push_exp(1);
    step(1'b1, 1'b1, 3'd2);
    settle();
    chk("R8 clear beats set", 64'(wr_valid), 1);
    chk("R8 ptr at 2", 64'(issue_ptr), 2);
    tick();
    push_exp(2);
    step(1'b1, 1'b0, '0);
    settle();
    chk("R6 scoreboard drained", 64'(expq.size()), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule